// File: doc/BRIEF.md
# Two-Lane Binary-Tree 16:1 Serializer

This block turns a 16-bit parallel word into a serial stream, one bit per fast bit clock, for each of two lanes. The conversion is not a shift register. It is a tree of four halving stages (16 to 8, 8 to 4, 4 to 2, 2 to 1). Each stage reloads at twice the rate of the stage feeding it. A chain of divide-by-two toggle stages, running off the one bit clock, produces every stage's load and half-select timing. All lanes share that chain, so they stay in lockstep.

The slowest divider stage is brought out as the word clock, at one sixteenth of the bit rate. Upstream logic presents a new word on each lane once per word-clock period. A static select input picks which word-clock edge latches the parallel inputs. With the rising edge chosen, the word is held in a second register until the falling-edge point before it enters the tree. As a result, both settings feed the tree at the same phase.

The design is cycle-accurate RTL on the bit clock, with clock enables in place of the divided clocks. Reset is synchronous and active low.

Top module: `tree_ser16`

## Requirements
- R1: Each lane sends bit 0 of a captured word first and bit 15 last, on consecutive bit clocks.
- R2: Consecutive words follow each other with no idle bit and no repeated bit: bit 0 of word n+1 comes on the bit clock right after bit 15 of word n.
- R3: The lanes share one timing chain and are otherwise independent. Lane k takes word_in[16k+15:16k] and drives ser_out[k].
- R4: word_clk is low for 8 bit clocks and then high for 8. After reset is released, it first goes high following the 8th bit-clock edge.
- R5: When cap_fall is 1, each lane samples its word at the bit-clock edge where word_clk falls. Bit 0 of that word appears 15 edges later.
- R6: When cap_fall is 0, each lane samples its word at the bit-clock edge where word_clk rises. Bit 0 of that word appears 23 edges later.
- R7: After reset is released, ser_out stays 0 for the first 30 bit-clock edges. The first captured word's bit 0 appears after edge 31, in either capture mode.
- R8: While rst_n is low, every clock edge clears the divider chain, the capture registers and all tree stages. This leaves ser_out and word_clk at 0 and restarts every stage in phase, including when reset arrives mid-stream.
- R9: In the divider chain, stage i (i ≥ 1) changes state only on an edge where all lower stages are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_fall | input | 1 | 1: latch words at the word-clock falling edge; 0: at the rising edge (change only during reset) |
| word_in | input | 32 | Parallel words, lane k in bits [16k+15:16k] |
| word_clk | output | 1 | Divided word clock, bit rate / 16 |
| ser_out | output | 2 | Serial bit per lane, bit k for lane k |

## Verification
Several properties are checked on every cycle:
- the exact 8-low and 8-high period of the word clock;
- the carry rule of the divider chain;
- the return of all divider stages to zero after reset;
- capture registers that change only on the selected word-clock edge;
- an all-zero output during the 30 edges after reset.

The bench's scenarios cover the behaviour that only a full data stream can show:
- the bit order inside a word;
- the seamless join between words;
- lane independence;
- the absolute 31-edge alignment in each capture mode;
- the clean restart after a mid-stream reset.

// File: rtl/tree_ser_pkg.sv
// Package: shared types and helpers for the tree serializer.
// Assumes the word width is a power of two.
package tree_ser_pkg;

    // Which word-clock edge latches the parallel input.
    typedef enum logic {
        CAPT_RISE = 1'b0,
        CAPT_FALL = 1'b1
    } capt_edge_e;

    // Bit offset of tree level j inside a flat vector holding all levels:
    // level 0 is the full word, level j holds w >> j bits.
    function automatic int tree_off(int w, int j);
        return 2 * w - 2 * (w >> j);
    endfunction

endpackage

// File: rtl/ser_div_chain.sv
// Divider chain: cascaded divide-by-two toggle stages on the bit clock.
// Stage 0 toggles every cycle. Stage i toggles when all lower stages are 1.
// Also gives the last-cycle-of-word strobe (all ones) and the
// mid-word strobe (cycle just before the top stage rises).
// Assumes a synchronous active-low reset clearing every stage together.
module ser_div_chain #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] div_q,
    output logic              wrap_o,
    output logic              mid_o
);

    logic [STAGES:0] carry;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic t_q;

        // Toggle stage i when every lower stage is high.
        always_ff @(posedge clk) begin
            if (!rst_n)        t_q <= 1'b0;
            else if (carry[i]) t_q <= ~t_q;
        end

        assign div_q[i]     = t_q;
        assign carry[i + 1] = carry[i] & t_q;
    end

    // Strobes derived from the carry chain.
    assign wrap_o = carry[STAGES];
    assign mid_o  = carry[STAGES-1] & ~div_q[STAGES-1];

endmodule

// File: rtl/ser_merge.sv
// One halving stage of the tree: a register of IN_W/2 bits.
// On a load cycle it takes the lower or the upper half of its input,
// as chosen by the select bit from the divider chain.
// Assumes the input stays stable across the two loads that read it.
module ser_merge #(
    parameter int IN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic              sel_i,
    input  logic [IN_W-1:0]   d_i,
    output logic [IN_W/2-1:0] q_o
);

    localparam int OW = IN_W / 2;

    // Load the selected half on the stage's load cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (ld_i) q_o <= sel_i ? d_i[IN_W-1:OW] : d_i[OW-1:0];
    end

endmodule

// File: rtl/ser_lane.sv
// One serializer lane.
// It has an edge capture register and an alignment register used in
// rising-edge mode. These feed LEVELS halving stages that end in one bit.
// Stage j reloads when the lower LEVELS-j divider bits are all ones.
// It picks its half by divider bit LEVELS-j.
// Assumes cap_fall is static outside reset.
module ser_lane
    import tree_ser_pkg::*;
#(
    parameter int W      = 16,
    parameter int LEVELS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_fall,
    input  logic              cap_en,
    input  logic              wrap_en,
    input  logic [LEVELS-1:0] div_q,
    input  logic [W-1:0]      word_i,
    output logic [W-1:0]      cap_q_o,
    output logic              bit_o
);

    logic [W-1:0]     edge_q;
    logic [W-1:0]     al_q;
    logic [2*W-2:0]   tv;
    capt_edge_e       edge_sel;

    assign edge_sel = capt_edge_e'(cap_fall);

    // Latch the parallel word on the selected word-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      edge_q <= '0;
        else if (cap_en) edge_q <= word_i;
    end

    // Move a rising-edge capture to the falling-edge phase of the tree.
    always_ff @(posedge clk) begin
        if (!rst_n)       al_q <= '0;
        else if (wrap_en) al_q <= edge_q;
    end

    assign tv[W-1:0] = (edge_sel == CAPT_FALL) ? edge_q : al_q;

    for (genvar j = 1; j <= LEVELS; j++) begin : g_lvl
        localparam int IW = W >> (j - 1);
        localparam int OW = W >> j;
        localparam int IO = tree_off(W, j - 1);
        localparam int OO = tree_off(W, j);
        localparam int SB = LEVELS - j;

        logic ld;

        if (SB == 0) begin : g_last
            assign ld = 1'b1;
        end else begin : g_mid
            assign ld = &div_q[SB-1:0];
        end

        ser_merge #(.IN_W(IW)) u_merge (
            .clk   (clk),
            .rst_n (rst_n),
            .ld_i  (ld),
            .sel_i (div_q[SB]),
            .d_i   (tv[IO+IW-1:IO]),
            .q_o   (tv[OO+OW-1:OO])
        );
    end

    assign cap_q_o = edge_q;
    assign bit_o   = tv[2*W-2];

endmodule

// File: rtl/tree_ser16.sv
// Top: multi-lane tree serializer sharing one divider chain.
// It brings out the word clock (top divider stage) and one serial bit
// per lane per bit clock.
// Assumes WORD_W is a power of two and cap_fall changes only in reset.
module tree_ser16 #(
    parameter int WORD_W = 16,
    parameter int N_CH   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_fall,
    input  logic [N_CH*WORD_W-1:0] word_in,
    output logic                   word_clk,
    output logic [N_CH-1:0]        ser_out
);

    localparam int LEVELS = $clog2(WORD_W);

    logic [LEVELS-1:0]      div_q;
    logic                   wrap_s;
    logic                   mid_s;
    logic                   cap_en;
    logic [N_CH*WORD_W-1:0] cap_all;

    ser_div_chain #(.STAGES(LEVELS)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_q  (div_q),
        .wrap_o (wrap_s),
        .mid_o  (mid_s)
    );

    // Capture strobe: falling-edge point or rising-edge point of word_clk.
    assign cap_en   = cap_fall ? wrap_s : mid_s;
    assign word_clk = div_q[LEVELS-1];

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        ser_lane #(.W(WORD_W), .LEVELS(LEVELS)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_fall (cap_fall),
            .cap_en   (cap_en),
            .wrap_en  (wrap_s),
            .div_q    (div_q),
            .word_i   (word_in[k*WORD_W +: WORD_W]),
            .cap_q_o  (cap_all[k*WORD_W +: WORD_W]),
            .bit_o    (ser_out[k])
        );
    end

endmodule

// File: rtl/tree_ser16_chk.sv
// Checker for tree_ser16: timing of the word clock, the divider carry
// rule, reset alignment, the capture edge and the zero fill after reset.
// Counters here bound the windows so no property looks far back.
module tree_ser16_chk #(
    parameter int W      = 16,
    parameter int NCH    = 2,
    parameter int LEVELS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_fall,
    input logic              word_clk,
    input logic [NCH-1:0]    ser_out,
    input logic [LEVELS-1:0] div_q,
    input logic [NCH*W-1:0]  cap_q
);

    localparam int SW = $clog2(W) + 1;
    localparam int FW = $clog2(2 * W) + 1;
    localparam logic [SW-1:0] HALF_V = SW'(W / 2);
    localparam logic [FW-1:0] FILL_V = FW'(2 * W - 1);

    logic [SW-1:0] since;
    logic          prev_wc;
    logic [FW-1:0] fill;

    // Count cycles since the last word-clock change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since   <= '0;
            prev_wc <= 1'b0;
        end else begin
            since   <= (word_clk != prev_wc) ? SW'(1) : since + 1'b1;
            prev_wc <= word_clk;
        end
    end

    // Count edges since reset release, saturating at the fill latency.
    always_ff @(posedge clk) begin
        if (!rst_n)             fill <= '0;
        else if (fill < FILL_V) fill <= fill + 1'b1;
    end

    // R4
    word_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_clk != prev_wc) |-> (since == HALF_V));

    // R4
    wc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_clk == prev_wc) |-> (since < HALF_V));

    // R7
    fill_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill < FILL_V) |-> (ser_out == '0));

    // R5 R6
    capture_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_q) |-> (cap_fall ? $fell(word_clk) : $rose(word_clk)));

    // R8
    reset_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (div_q == '0));

    for (genvar i = 1; i < LEVELS; i++) begin : g_carry
        // R9
        carry_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(div_q[i]) |-> ($past(div_q[i-1:0]) == '1));
    end

endmodule

bind tree_ser16 tree_ser16_chk #(
    .W      (WORD_W),
    .NCH    (N_CH),
    .LEVELS (LEVELS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_fall (cap_fall),
    .word_clk (word_clk),
    .ser_out  (ser_out),
    .div_q    (div_q),
    .cap_q    (cap_all)
);

// File: tb/tree_ser16_test.sv
`timescale 1ns/1ps
// Scoreboard bench: put_word pushes the expected bits of each lane into
// queues, and a monitor pops and compares them once the stream starts.
module tree_ser16_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_fall = 1'b1;
    logic [31:0] word_in = '0;
    logic        word_clk;
    logic [1:0]  ser_out;

    int    checks = 0;
    int    errors = 0;
    int    e = 0;
    bit    done = 1'b0;
    string mtag = "R5";
    bit    qa[$];
    bit    qb[$];

    always #2.5 clk = ~clk;

    tree_ser16 uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_fall (cap_fall),
        .word_in  (word_in),
        .word_clk (word_clk),
        .ser_out  (ser_out)
    );

    // Released-edge counter: e edges have passed since reset release.
    always @(posedge clk) begin
        if (!rst_n) e <= 0;
        else        e <= e + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (e=%0d)", tag, act, exp, e);
        end
    endtask

    function automatic logic [15:0] pat_a(input int i);
        case (i)
            0: return 16'h8001;
            1: return 16'hFFFF;
            2: return 16'h0000;
            3: return 16'hAAAA;
            4: return 16'h0001;
            default: return 16'((i * 40503) ^ 16'h5A5A);
        endcase
    endfunction

    // Driver: present word idx on both lanes and push the expected bits.
    task automatic put_word(input int idx);
        logic [15:0] a;
        logic [15:0] b;
        a = pat_a(idx);
        b = {a[7:0], a[15:8]} ^ 16'h0F0F;
        word_in = {b, a};
        for (int i = 0; i < 16; i++) begin
            qa.push_back(a[i]);
            qb.push_back(b[i]);
        end
    endtask

    // Monitor: word-clock phase, zero fill, then bit-by-bit compare.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(word_clk == ((e % 16) >= 8), "R4 R9 word clock phase",
                word_clk, int'((e % 16) >= 8));
            if (e < 31) begin
                chk(ser_out == 2'b00, "R7 zero before first word", ser_out, 0);
            end else if (qa.size() > 0) begin
                bit ea;
                bit eb;
                ea = qa.pop_front();
                eb = qb.pop_front();
                chk(ser_out[0] == ea, {"R1 R2 lane0 ", mtag}, ser_out[0], ea);
                chk(ser_out[1] == eb, {"R3 lane1 ", mtag}, ser_out[1], eb);
            end
        end
    end

    // One run: reset, choose mode, stream words; optionally cut by reset.
    task automatic run_phase(input bit fall, input int nwords, input bit full);
        int sent;
        int sp;
        rst_n    = 1'b0;
        cap_fall = fall;
        mtag     = fall ? "R5" : "R6";
        qa.delete();
        qb.delete();
        put_word(0);
        repeat (3) @(negedge clk);
        chk(ser_out == 2'b00, "R8 reset clears output", ser_out, 0);
        chk(word_clk == 1'b0, "R8 reset clears word clock", word_clk, 0);
        rst_n = 1'b1;
        sent  = 1;
        sp    = fall ? 0 : 8;
        while (sent < nwords) begin
            @(negedge clk);
            if (e > 0 && (e % 16) == sp) begin
                put_word(sent);
                sent++;
            end
        end
        if (full) begin
            while (qa.size() != 0) @(negedge clk);
            repeat (2) @(negedge clk);
        end else begin
            repeat (5) @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk(ser_out == 2'b00, "R8 mid-stream reset output", ser_out, 0);
            chk(word_clk == 1'b0, "R8 mid-stream reset word clock", word_clk, 0);
            qa.delete();
            qb.delete();
        end
    endtask

    initial begin
        run_phase(1'b1, 10, 1'b1);
        run_phase(1'b0, 10, 1'b1);
        run_phase(1'b1, 4, 1'b0);
        run_phase(1'b0, 6, 1'b1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule